// File: doc/BRIEF.md
# Cascadable Up/Down Binary Counter

This block is a synchronous binary counter of parameterised width (four bits by default). All count bits move together on a rising clock edge, and only while an active-low count enable is asserted. A direction input chooses between incrementing and decrementing. The count wraps at both ends of its range.

An active-low parallel load acts asynchronously. While it is low, the output follows the data input at once, with no clock edge needed, and clock edges are ignored. Counting picks up again on the first rising edge after the load is released.

Two outputs let several counters be chained into a wider one. The terminal flag is high while the counter is enabled and sits at the value it would wrap from in the current direction. The active-low ripple output copies that flag, but only during the low half of the clock. Feeding the ripple output of one stage into the clock input of the next, with the next stage's enable held low, gives a wider counter. In that arrangement the next stage steps exactly on the edge where the lower stage wraps.

Top module: `udc_counter`

## Requirements
- R1: With the enable low, the direction low and the load high, each rising clock edge adds one to the count, and the all-ones value wraps to 0.
- R2: With the enable low, the direction high and the load high, each rising clock edge subtracts one from the count, and 0 wraps to the all-ones value.
- R3: With the enable high, rising clock edges leave the count unchanged in either direction.
- R4: While the load is low, the count output equals the data input, including between clock edges and before any edge has occurred.
- R5: While the load is low, clock edges do not count. The value loaded is kept until the first rising edge after the load returns high, and counting resumes on that edge.
- R6: The terminal flag is high exactly when the enable is low and the count is all ones with the direction low, or 0 with the direction high. A stage whose enable is high never raises it.
- R7: The ripple output is low exactly when the terminal flag is high and the clock is low. It is high throughout the clock's high phase.
- R8: Two stages, with the low stage's ripple output driving the high stage's clock and the high stage's enable tied low, count as one 2·WIDTH-bit counter in both directions, across carry and borrow.
- R9: A change of the enable or the direction between clock edges leaves the count unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock; counting happens on its rising edge |
| cnt_en_n | input | 1 | Active-low count enable |
| dir_dn | input | 1 | Direction: 0 counts up, 1 counts down |
| load_n | input | 1 | Active-low asynchronous parallel load |
| din | input | WIDTH | Value to load |
| q | output | WIDTH | Current count |
| term_hit | output | 1 | Terminal flag for the current direction, qualified by the enable |
| ripple_n | output | 1 | Active-low cascade pulse: terminal flag gated by the clock's low phase |

## Verification
The bench builds two four-bit stages. The low stage uses the toggle-chain step logic and the high stage uses the adder step logic, so both step variants run inside one eight-bit chain. With four bits per stage, a full wrap of the combined count takes 256 edges. This lets the bench walk through every carry and borrow boundary of the high stage, and through its own wrap, in both directions. Loads are applied during the clock's high phase. They are checked before the next edge and again after clock edges that arrive while the load is held low.

// File: rtl/udc_pkg.sv
package udc_pkg;
   typedef enum logic {
      DIR_UP   = 1'b0,
      DIR_DOWN = 1'b1
   } udc_dir_e;

   localparam int STYLE_ADDER  = 0;
   localparam int STYLE_TOGGLE = 1;
endpackage

// File: rtl/udc_step.sv
module udc_step #(
   parameter int WIDTH = 4,
   parameter int STYLE = udc_pkg::STYLE_TOGGLE
) (
   input  logic [WIDTH-1:0] cur,
   input  logic             down,
   output logic [WIDTH-1:0] nxt
);
   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   generate
      if (STYLE == udc_pkg::STYLE_ADDER) begin : g_adder
         always_comb begin
            if (down == udc_pkg::DIR_DOWN) nxt = cur - ONE;
            else                           nxt = cur + ONE;
         end
      end else if (STYLE == udc_pkg::STYLE_TOGGLE) begin : g_toggle
         // bit i flips when all lower bits are 1 (up) or 0 (down)
         logic [WIDTH-1:0] cmp;
         logic [WIDTH-1:0] tog;
         assign cmp = down ? ~cur : cur;
         always_comb begin
            logic run;
            run = 1'b1;
            for (int i = 0; i < WIDTH; i++) begin
               tog[i] = run;
               run    = run & cmp[i];
            end
         end
         assign nxt = cur ^ tog;
      end else begin : g_bad_style
         $error("udc_step: unknown STYLE %0d", STYLE);
      end
   endgenerate
endmodule

// File: rtl/udc_term.sv
module udc_term #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] cnt,
   input  logic             down,
   input  logic             en_n,
   output logic             hit
);
   localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};
   localparam logic [WIDTH-1:0] BOT = '0;

   logic at_end;
   assign at_end = down ? (cnt == BOT) : (cnt == TOP);
   assign hit    = ~en_n & at_end;
endmodule

// File: rtl/udc_rco.sv
module udc_rco (
   input  logic clk,
   input  logic hit,
   output logic rco_n
);
   assign rco_n = ~(hit & ~clk);
endmodule

// File: rtl/udc_counter.sv
module udc_counter #(
   parameter int WIDTH      = 4,
   parameter int STEP_STYLE = udc_pkg::STYLE_TOGGLE
) (
   input  logic             clk,
   input  logic             cnt_en_n,
   input  logic             dir_dn,
   input  logic             load_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] q,
   output logic             term_hit,
   output logic             ripple_n
);
   localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
   localparam logic [WIDTH-1:0] ONES = {WIDTH{1'b1}};

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("udc_counter: WIDTH must be at least 2, got %0d", WIDTH);
      end
   endgenerate

   logic [WIDTH-1:0] state_r;
   logic [WIDTH-1:0] step_v;

   udc_step #(.WIDTH(WIDTH), .STYLE(STEP_STYLE)) u_step (
      .cur  (state_r),
      .down (dir_dn),
      .nxt  (step_v)
   );

   // asynchronous preset; edges during load keep tracking din
   always_ff @(posedge clk or negedge load_n) begin
      if (!load_n)        state_r <= din;
      else if (!cnt_en_n) state_r <= step_v;
   end

   assign q = load_n ? state_r : din;

   udc_term #(.WIDTH(WIDTH)) u_term (
      .cnt  (q),
      .down (dir_dn),
      .en_n (cnt_en_n),
      .hit  (term_hit)
   );

   udc_rco u_rco (
      .clk   (clk),
      .hit   (term_hit),
      .rco_n (ripple_n)
   );

   // marks that a load was seen since the previous rising edge
   logic ld_mark;
   always_ff @(posedge clk or negedge load_n) begin
      if (!load_n) ld_mark <= 1'b1;
      else         ld_mark <= 1'b0;
   end

   p_count_up_r1: assert property (@(posedge clk) disable iff (!load_n)
      (!cnt_en_n && !dir_dn) |=> (ld_mark || q == $past(q) + ONE));

   p_count_dn_r2: assert property (@(posedge clk) disable iff (!load_n)
      (!cnt_en_n && dir_dn) |=> (ld_mark || q == $past(q) - ONE));

   p_hold_r3: assert property (@(posedge clk) disable iff (!load_n)
      cnt_en_n |=> (ld_mark || q == $past(q)));

   p_load_follow_r4: assert property (@(posedge clk)
      !load_n |-> (q == din));

   p_release_r5: assert property (@(posedge clk) disable iff (!load_n)
      $rose(load_n) |-> (q == $past(din)));

   p_term_wrap_r6: assert property (@(posedge clk) disable iff (!load_n)
      term_hit |=> (ld_mark || q == ($past(dir_dn) ? ONES : '0)));

   p_rco_low_r7: assert property (@(posedge clk)
      term_hit |-> !ripple_n);

   p_rco_high_r7: assert property (@(negedge clk)
      ripple_n);
endmodule

// File: tb/udc_counter_test.sv
module udc_counter_test;
   localparam int CLK_P = 10;
   localparam int W     = 4;
   localparam int MODV  = 1 << W;

   logic         clk    = 1'b0;
   logic         en_n   = 1'b1;
   logic         dir    = 1'b0;
   logic         ld0_n  = 1'b1;
   logic         ld1_n  = 1'b1;
   logic [W-1:0] din0   = '0;
   logic [W-1:0] din1   = '0;
   logic [W-1:0] q0, q1;
   logic         t0, t1, r0, r1;

   int m0 = 0;
   int m1 = 0;
   int nvec = 0;
   int nfail = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   udc_counter #(.WIDTH(W), .STEP_STYLE(udc_pkg::STYLE_TOGGLE)) uut (
      .clk(clk), .cnt_en_n(en_n), .dir_dn(dir), .load_n(ld0_n), .din(din0),
      .q(q0), .term_hit(t0), .ripple_n(r0));

   udc_counter #(.WIDTH(W), .STEP_STYLE(udc_pkg::STYLE_ADDER)) uut_hi (
      .clk(r0), .cnt_en_n(1'b0), .dir_dn(dir), .load_n(ld1_n), .din(din1),
      .q(q1), .term_hit(t1), .ripple_n(r1));

   // behavioural reference: both stages updated on the shared clock edge
   always @(posedge clk) begin
      bit carry;
      carry = !en_n && (dir ? (m0 == 0) : (m0 == MODV - 1));
      if (!ld0_n) m0 = din0;
      else if (!en_n) m0 = dir ? (m0 + MODV - 1) % MODV : (m0 + 1) % MODV;
      if (!ld1_n) m1 = din1;
      else if (carry) m1 = dir ? (m1 + MODV - 1) % MODV : (m1 + 1) % MODV;
   end

   task automatic check(input string tag);
      bit et0, er0, et1, er1;
      et0 = !en_n && (dir ? (m0 == 0) : (m0 == MODV - 1));
      er0 = !(et0 && !clk);
      et1 = dir ? (m1 == 0) : (m1 == MODV - 1);
      er1 = !(et1 && !er0);
      nvec++;
      if (q0 !== W'(m0) || q1 !== W'(m1) || t0 !== et0 || r0 !== er0 ||
          t1 !== et1 || r1 !== er1) begin
         nfail++;
         $display("FAIL %s @%0t: q1:q0=%0d:%0d exp %0d:%0d t0/r0=%b%b exp %b%b t1/r1=%b%b exp %b%b",
                  tag, $time, q1, q0, m1, m0, t0, r0, et0, er0, t1, r1, et1, er1);
      end
   endtask

   // checks in the low phase, then in the high phase; returns at posedge+2
   task automatic step(input string tag);
      @(negedge clk); #2 check(tag);
      @(posedge clk); #2 check(tag);
   endtask

   task automatic load0(input logic [W-1:0] v);
      din0 = v; ld0_n = 1'b0; m0 = v;
   endtask

   task automatic load1(input logic [W-1:0] v);
      din1 = v; ld1_n = 1'b0; m1 = v;
   endtask

   initial begin
      #1;
      load0(4'd0); load1(4'd0);
      @(posedge clk); #2 check("R4 initial load");
      ld0_n = 1'b1; ld1_n = 1'b1;
      // R3: enable high holds in both directions
      for (int i = 0; i < 3; i++) step("R3 hold up");
      dir = 1'b1;
      for (int i = 0; i < 3; i++) step("R3 hold down, R6 no flag when disabled");
      // R1, R8: count up across several carries
      dir = 1'b0; en_n = 1'b0;
      for (int i = 0; i < 40; i++) step("R1 R8 up count");
      // R9: direction change between edges does not move q
      dir = 1'b1; #1 check("R9 dir change no effect");
      en_n = 1'b1; #1 check("R9 enable change no effect");
      en_n = 1'b0;
      // R2, R8: count down across borrows
      for (int i = 0; i < 60; i++) step("R2 R8 down count");
      // R4, R5: mid-cycle load, edges ignored while held
      load0(4'd9); #1 check("R4 load immediate");
      for (int i = 0; i < 3; i++) step("R5 edges ignored during load");
      ld0_n = 1'b1;
      for (int i = 0; i < 3; i++) step("R5 resume after release");
      // R6, R7: terminal at all-ones counting up, then disabled
      dir = 1'b0; load0(4'd15); #1 check("R6 terminal after load");
      en_n = 1'b1; #1 check("R6 terminal qualified by enable");
      ld0_n = 1'b1;
      step("R6 R7 disabled stage gives no ripple");
      en_n = 1'b0;
      step("R7 ripple pulse and carry");
      // R2, R6: borrow from zero in the low stage
      dir = 1'b1; load0(4'd0); load1(4'd0); #1 check("R4 zero load both");
      ld0_n = 1'b1; ld1_n = 1'b1;
      for (int i = 0; i < 4; i++) step("R2 R6 R8 borrow through zero");
      // R8: full eight-bit wrap upward
      dir = 1'b0;
      for (int i = 0; i < 270; i++) step("R1 R8 eight-bit wrap");
      // R8: high-stage load mid-run, then count down to wrap
      load1(4'd3); #1 check("R4 high stage load");
      ld1_n = 1'b1;
      dir = 1'b1;
      for (int i = 0; i < 80; i++) step("R2 R8 down from loaded high stage");
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog: run hung, actual running, expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   end
endmodule